// File: doc/BRIEF.md
# I/O Translation Unit Register Bank

This block is the software-visible register file of an I/O address translation unit. A host reaches it through a simple word-wide register bus. The bus carries a word index, a read strobe, a write strobe and write data. Read data returns one cycle after the strobe. Each register keeps only its writable bits and forces the bits that must stay set. One identification register accumulates bits and can never have them cleared.

The block turns the window-size code in the control register into the start address of the translation window. It also drives a level interrupt. Fault capture logic next to the block loads the fault status and fault address through a dedicated port, and that load raises the interrupt. Software lowers the interrupt by reading or writing either fault register. The block does no translation, arbitration or flushing. It only holds the values that other logic consumes.

Top module: `iommu_regbank`

## Requirements
- R1: After reset the registers read as follows: control = VERSION, fault status = 0x00800000, arbiter enable = 0x00000003, arbitration enable = 0x00000008, mask ID = 0x23000000. All other registers read 0. `win_start` and `irq` are 0.
- R2: A write to the control register (word 0x000) stores (data & 0x0000001D) | VERSION. Bit 0 is the translation enable.
- R3: A control write loads `win_start` with 2^32 minus the window size. Control bits 4:2 select the size, from 16 MB (code 0) doubling to 2 GB (code 7). Code 0 gives 0xFF000000, code 1 gives 0xFE000000 and code 7 gives 0x80000000. The new value is visible in the cycle after the write.
- R4: A write to the page-table base (word 0x001) keeps only the bits in 0x07FFFC00. The full-flush register (word 0x005) and the page-flush register (word 0x006) keep all 32 bits.
- R5: A bus write to fault status (word 0x400) stores (data & 0xFF0FFFFF) | 0x00800000. A bus write to fault address (word 0x401) stores all 32 bits.
- R6: A write to arbiter enable (word 0x402) stores (data & 0x801F000F) | 0x00000001.
- R7: The four slot configuration registers (words 0x404 to 0x407) keep the bits in 0x00010003. A write to arbitration enable (word 0x800) stores (data & 0x001F0000) | 0x00000008.
- R8: A write to mask ID (word 0xC06) ORs (data & 0x00FFFFFF) into the current value. Bits can be set but never cleared.
- R9: A `flt_load` pulse stores `flt_status | 0x00800000` into fault status and `flt_addr` into fault address, and sets `irq` in the next cycle. If a bus write to a fault register occurs in the same cycle, the captured values and the interrupt take effect and the bus write is dropped.
- R10: When no `flt_load` is present, a read or write of fault status or fault address clears `irq` in the next cycle. Accesses to any other register leave `irq` unchanged.
- R11: Words that map to no register read as 0 and ignore writes.
- R12: `bus_rdata` shows the addressed value in the cycle after `bus_rd`, taken before any write in the same cycle. In any cycle that follows a cycle without `bus_rd`, `bus_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Word index of the accessed register |
| bus_rd | input | 1 | Read strobe |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| flt_load | input | 1 | Fault capture strobe |
| flt_status | input | 32 | Fault status to capture |
| flt_addr | input | 32 | Faulting address to capture |
| win_start | output | 32 | Start address of the translation window |
| irq | output | 1 | Level fault interrupt |

## Verification
The bench builds the block with VERSION = 0x41000000, ADDR_W = 12 and NSLOT = 4. A nonzero version exposes any path that drops or corrupts the constant merged into control writes. Four slots bring both ends of the slot range within reach, so a slot hit can be told apart from the unmapped words beside it. The 12-bit index makes the high arbitration-enable and mask-ID words reachable.

// File: rtl/iommu_regbank_pkg.sv
package iommu_regbank_pkg;
  localparam int W_CTRL   = 'h000;
  localparam int W_BASE   = 'h001;
  localparam int W_TFLUSH = 'h005;
  localparam int W_PFLUSH = 'h006;
  localparam int W_FSR    = 'h400;
  localparam int W_FAR    = 'h401;
  localparam int W_AER    = 'h402;
  localparam int W_SLOT0  = 'h404;
  localparam int W_ARBEN  = 'h800;
  localparam int W_MASKID = 'hC06;

  localparam logic [31:0] M_CTRL   = 32'h0000_001D;
  localparam logic [31:0] M_BASE   = 32'h07FF_FC00;
  localparam logic [31:0] M_FSR    = 32'hFF0F_FFFF;
  localparam logic [31:0] F_FSR    = 32'h0080_0000;
  localparam logic [31:0] M_AER    = 32'h801F_000F;
  localparam logic [31:0] F_AER    = 32'h0000_0001;
  localparam logic [31:0] M_SLOT   = 32'h0001_0003;
  localparam logic [31:0] M_ARBEN  = 32'h001F_0000;
  localparam logic [31:0] F_ARBEN  = 32'h0000_0008;
  localparam logic [31:0] M_MASKID = 32'h00FF_FFFF;

  localparam logic [31:0] RST_AER    = 32'h0000_0003;
  localparam logic [31:0] RST_MASKID = 32'h2300_0000;
endpackage

// File: rtl/iommu_win_decode.sv
module iommu_win_decode #(
  parameter int MIN_SHIFT = 24,
  parameter int CODE_W    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [CODE_W-1:0] code,
  output logic [31:0]       win_start
);
  logic [32:0] size;
  logic [32:0] start_full;

  always_comb begin
    size       = 33'd1 << (MIN_SHIFT + int'(code));
    start_full = 33'h1_0000_0000 - size;
  end

  always_ff @(posedge clk) begin
    if (rst)       win_start <= '0;
    else if (load) win_start <= start_full[31:0];
  end

  // every window is at least 16 MB, so the low bits of its start are clear
  assert_win_align_R3: assert property (@(posedge clk) disable iff (rst)
    load |=> (win_start[MIN_SHIFT-1:0] == '0) && win_start[31]);
endmodule

// File: rtl/iommu_irq_ctl.sv
module iommu_irq_ctl (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (rst)      irq <= 1'b0;
    else if (set) irq <= 1'b1;
    else if (clr) irq <= 1'b0;
  end

  assert_irq_set_R9: assert property (@(posedge clk) disable iff (rst)
    set |=> irq);
  assert_irq_clr_R10: assert property (@(posedge clk) disable iff (rst)
    (clr && !set) |=> !irq);
  assert_irq_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!clr && !set) |=> $stable(irq));
endmodule

// File: rtl/iommu_slot_bank.sv
module iommu_slot_bank #(
  parameter int          NSLOT = 4,
  parameter logic [31:0] MASK  = 32'h0001_0003
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [NSLOT-1:0] sel,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata
);
  logic [31:0] cfg_q [NSLOT];
  logic [31:0] pick  [NSLOT];

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)                 cfg_q[i] <= '0;
      else if (we && sel[i])   cfg_q[i] <= wdata & MASK;
    end
    assign pick[i] = sel[i] ? cfg_q[i] : '0;
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NSLOT; i++) rdata |= pick[i];
  end

  assert_slot_sel_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel));
endmodule

// File: rtl/iommu_regbank.sv
module iommu_regbank
  import iommu_regbank_pkg::*;
#(
  parameter int          ADDR_W  = 12,
  parameter logic [31:0] VERSION = 32'h0000_0000,
  parameter int          NSLOT   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              flt_load,
  input  logic [31:0]       flt_status,
  input  logic [31:0]       flt_addr,
  output logic [31:0]       win_start,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(W_CTRL);
  localparam logic [ADDR_W-1:0] A_BASE   = ADDR_W'(W_BASE);
  localparam logic [ADDR_W-1:0] A_TFLUSH = ADDR_W'(W_TFLUSH);
  localparam logic [ADDR_W-1:0] A_PFLUSH = ADDR_W'(W_PFLUSH);
  localparam logic [ADDR_W-1:0] A_FSR    = ADDR_W'(W_FSR);
  localparam logic [ADDR_W-1:0] A_FAR    = ADDR_W'(W_FAR);
  localparam logic [ADDR_W-1:0] A_AER    = ADDR_W'(W_AER);
  localparam logic [ADDR_W-1:0] A_ARBEN  = ADDR_W'(W_ARBEN);
  localparam logic [ADDR_W-1:0] A_MASKID = ADDR_W'(W_MASKID);

  logic [31:0] ctrl_q, base_q, tflush_q, pflush_q;
  logic [31:0] fsr_q, far_q, aer_q, arben_q, mask_q;
  logic [NSLOT-1:0] slot_sel;
  logic [31:0] slot_rdata;
  logic [31:0] rd_val;
  logic        flt_access;
  logic        ctrl_wr;

  for (genvar i = 0; i < NSLOT; i++) begin : g_sel
    assign slot_sel[i] = (bus_addr == ADDR_W'(W_SLOT0 + i));
  end

  assign flt_access = (bus_rd || bus_we) && (bus_addr == A_FSR || bus_addr == A_FAR);
  assign ctrl_wr    = bus_we && (bus_addr == A_CTRL);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= VERSION;
      base_q   <= '0;
      tflush_q <= '0;
      pflush_q <= '0;
      fsr_q    <= F_FSR;
      far_q    <= '0;
      aer_q    <= RST_AER;
      arben_q  <= F_ARBEN;
      mask_q   <= RST_MASKID;
    end else begin
      if (bus_we) begin
        case (bus_addr)
          A_CTRL:   ctrl_q   <= (bus_wdata & M_CTRL) | VERSION;
          A_BASE:   base_q   <= bus_wdata & M_BASE;
          A_TFLUSH: tflush_q <= bus_wdata;
          A_PFLUSH: pflush_q <= bus_wdata;
          A_FSR:    fsr_q    <= (bus_wdata & M_FSR) | F_FSR;
          A_FAR:    far_q    <= bus_wdata;
          A_AER:    aer_q    <= (bus_wdata & M_AER) | F_AER;
          A_ARBEN:  arben_q  <= (bus_wdata & M_ARBEN) | F_ARBEN;
          A_MASKID: mask_q   <= mask_q | (bus_wdata & M_MASKID);
          default: ;
        endcase
      end
      // capture port has priority over a same-cycle bus write
      if (flt_load) begin
        fsr_q <= flt_status | F_FSR;
        far_q <= flt_addr;
      end
    end
  end

  always_comb begin
    case (bus_addr)
      A_CTRL:   rd_val = ctrl_q;
      A_BASE:   rd_val = base_q;
      A_TFLUSH: rd_val = tflush_q;
      A_PFLUSH: rd_val = pflush_q;
      A_FSR:    rd_val = fsr_q;
      A_FAR:    rd_val = far_q;
      A_AER:    rd_val = aer_q;
      A_ARBEN:  rd_val = arben_q;
      A_MASKID: rd_val = mask_q;
      default:  rd_val = slot_rdata;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= bus_rd ? rd_val : '0;
  end

  iommu_slot_bank #(.NSLOT(NSLOT), .MASK(M_SLOT)) u_slots (
    .clk(clk), .rst(rst), .we(bus_we), .sel(slot_sel),
    .wdata(bus_wdata), .rdata(slot_rdata)
  );

  iommu_win_decode #(.MIN_SHIFT(24), .CODE_W(3)) u_win (
    .clk(clk), .rst(rst), .load(ctrl_wr), .code(bus_wdata[4:2]),
    .win_start(win_start)
  );

  iommu_irq_ctl u_irq (
    .clk(clk), .rst(rst), .set(flt_load), .clr(flt_access), .irq(irq)
  );

  assert_rdata_idle_R12: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> bus_rdata == '0);
  assert_fsr_forced_R5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> fsr_q[23]);
  assert_aer_forced_R6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> aer_q[0]);
  assert_mask_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((mask_q & $past(mask_q)) == $past(mask_q)));
  assert_capture_wins_R9: assert property (@(posedge clk) disable iff (rst)
    flt_load |=> far_q == $past(flt_addr));
endmodule

// File: tb/test_iommu_regbank.sv
module test_iommu_regbank;
  localparam logic [31:0] VER = 32'h4100_0000;
  localparam int AW = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic bus_rd = 1'b0, bus_we = 1'b0, flt_load = 1'b0;
  logic [31:0] bus_wdata = '0, flt_status = '0, flt_addr = '0;
  logic [31:0] bus_rdata, win_start;
  logic irq;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  iommu_regbank #(.ADDR_W(AW), .VERSION(VER), .NSLOT(4)) i_iommu_regbank (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .flt_load(flt_load),
    .flt_status(flt_status), .flt_addr(flt_addr), .win_start(win_start), .irq(irq)
  );

  // {word index, write data, expected read-back}, walked in order
  localparam int NV = 17;
  localparam logic [75:0] VEC [NV] = '{
    {12'h000, 32'hFFFF_FFFF, 32'h4100_001D},  // R2
    {12'h001, 32'hFFFF_FFFF, 32'h07FF_FC00},  // R4
    {12'h005, 32'hDEAD_BEEF, 32'hDEAD_BEEF},  // R4
    {12'h006, 32'h1234_5678, 32'h1234_5678},  // R4
    {12'h400, 32'h0000_0000, 32'h0080_0000},  // R5
    {12'h400, 32'hFFFF_FFFF, 32'hFF8F_FFFF},  // R5
    {12'h401, 32'hCAFE_F00D, 32'hCAFE_F00D},  // R5
    {12'h402, 32'h0000_0000, 32'h0000_0001},  // R6
    {12'h402, 32'hFFFF_FFFF, 32'h801F_000F},  // R6
    {12'h404, 32'hFFFF_FFFF, 32'h0001_0003},  // R7
    {12'h407, 32'h0001_0001, 32'h0001_0001},  // R7
    {12'h800, 32'h0000_0000, 32'h0000_0008},  // R7
    {12'h800, 32'hFFFF_FFFF, 32'h001F_0008},  // R7
    {12'hC06, 32'h0000_0001, 32'h2300_0001},  // R8
    {12'hC06, 32'h0000_0000, 32'h2300_0001},  // R8
    {12'h008, 32'hFFFF_FFFF, 32'h0000_0000},  // R11
    {12'h408, 32'hFFFF_FFFF, 32'h0000_0000}   // R11
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%08h exp=%08h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic capture(input logic [31:0] s, input logic [31:0] a);
    @(negedge clk);
    flt_status = s; flt_addr = a; flt_load = 1'b1;
    @(negedge clk);
    flt_load = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset values
    check("R1 irq", {31'd0, irq}, 32'd0);
    check("R1 win_start", win_start, 32'd0);
    rd(12'h000, v); check("R1 ctrl", v, VER);
    rd(12'h400, v); check("R1 fsr", v, 32'h0080_0000);
    rd(12'h402, v); check("R1 aer", v, 32'h0000_0003);
    rd(12'h800, v); check("R1 arben", v, 32'h0000_0008);
    rd(12'hC06, v); check("R1 maskid", v, 32'h2300_0000);
    rd(12'h001, v); check("R1 base", v, 32'h0);

    // R12 no read strobe gives zero data
    @(negedge clk);
    check("R12 idle rdata", bus_rdata, 32'h0);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][75:64], VEC[i][63:32]);
      rd(VEC[i][75:64], v);
      check($sformatf("vec%0d R2-table", i), v, VEC[i][31:0]);
    end

    // R3 window start per code
    wr(12'h000, 32'h0000_0000); check("R3 code0", win_start, 32'hFF00_0000);
    wr(12'h000, 32'h0000_0004); check("R3 code1", win_start, 32'hFE00_0000);
    wr(12'h000, 32'h0000_0011); check("R3 code4", win_start, 32'hF000_0000);
    wr(12'h000, 32'h0000_001C); check("R3 code7", win_start, 32'h8000_0000);

    // R9 capture loads and raises irq
    capture(32'h4000_0001, 32'h0123_4000);
    check("R9 irq set", {31'd0, irq}, 32'd1);
    // R10 access to other register keeps irq
    rd(12'h001, v);
    check("R10 other access", {31'd0, irq}, 32'd1);
    rd(12'h400, v);
    check("R9 fsr capture", v, 32'h4080_0001);
    check("R10 read clears", {31'd0, irq}, 32'd0);
    rd(12'h401, v);
    check("R9 far capture", v, 32'h0123_4000);

    capture(32'h0, 32'h5);
    wr(12'h401, 32'h0);
    check("R10 write clears", {31'd0, irq}, 32'd0);

    // R9 capture beats same-cycle bus write
    @(negedge clk);
    bus_addr = 12'h400; bus_wdata = 32'h0000_0000; bus_we = 1'b1;
    flt_status = 32'h1000_0002; flt_addr = 32'hAAAA_0000; flt_load = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; flt_load = 1'b0;
    check("R9 collide irq", {31'd0, irq}, 32'd1);
    rd(12'h400, v); check("R9 collide fsr", v, 32'h1080_0002);

    // R12 read returns pre-write value in a combined cycle
    @(negedge clk);
    bus_addr = 12'h005; bus_wdata = 32'h0BAD_F00D; bus_we = 1'b1; bus_rd = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_rd = 1'b0;
    check("R12 read before write", bus_rdata, 32'hDEAD_BEEF);

    finish_run();
  end
endmodule